// File: doc/BRIEF.md
# Serial Transmitter with Stretched Start Bit

The block sends bytes as asynchronous serial frames: one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts a configurable number of clock cycles. To help a receiver that samples late, the start bit can be lengthened by a few cycles. The same number of cycles is taken away from the stop bit, so the frame length does not change.

The serial line is bit 0 of an 8-bit output port. The line behaves like an open-collector output: a 1 releases it (idle high) and a 0 pulls it low. Port bits 7..1 carry stepper-motor phase outputs. These bits are loaded through their own strobe and the transmitter never disturbs them.

Bytes enter through a valid/ready handshake. The timing configuration is captured when a byte is accepted.

Top module: `sertx_port`

## Requirements
- R1: After a synchronous active-low reset, `port_out` is 8'h01 (line high, phase bits 0), `busy` is 0 and `tx_ready` is 1.
- R2: A frame is a low start bit, then data bits 0 through 7 in that order, then a high stop bit. The start bit appears on `port_out[0]` in the cycle after the handshake.
- R3: Each data bit lasts `bit_cycles` clock cycles. The start bit lasts `bit_cycles + start_ext` cycles.
- R4: The stop bit lasts `stop_cycles - start_ext` cycles. The busy period of a frame is therefore `9*bit_cycles + stop_cycles` for any extension that does not trigger R5.
- R5: When `stop_cycles - start_ext` is less than `bit_cycles`, the stop bit lasts exactly `bit_cycles` cycles.
- R6: `tx_ready` is high while idle and in the final stop-bit cycle. A byte offered then starts its start bit directly after the stop bit, with no idle cycle in between.
- R7: A `phase_load` pulse puts `phase_val` on `port_out[7:1]` in the next cycle. Without a pulse, those bits keep their value, including across every transmitter change of bit 0.
- R8: With no frame in progress, `port_out[0]` is 1.
- R9: `busy` rises in the cycle after acceptance and stays high until the stop bit ends. It falls in the cycle after the last stop cycle unless a back-to-back byte was accepted.
- R10: Changing the configuration inputs during a frame does not change that frame's timing. The values present at acceptance apply to the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Byte offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Byte will be taken on this edge if valid |
| bit_cycles | input | 5 | Cycles per start or data bit (0 acts as 1) |
| stop_cycles | input | 5 | Nominal stop-bit cycles before extension |
| start_ext | input | 5 | Cycles moved from stop bit to start bit |
| phase_load | input | 1 | Load strobe for stepper phase bits |
| phase_val | input | 7 | New stepper phase value |
| port_out | output | 8 | Bit 0 serial line, bits 7..1 stepper phases |
| busy | output | 1 | Frame in progress |

## Verification
Two things can happen in the same cycle: a stepper phase load, and a transmitter change of the serial bit. In the worst case that change is the accept edge, where the line drops for a start bit. The bench forces this collision directly with a phase pulse on the acceptance edge. It also provokes it at random by pulsing `phase_load` at arbitrary cycles while random frames run with random spacing.

A cycle-accurate trace of `port_out` is judged two ways. Bit 0 is compared against a frame waveform computed from R2 to R5. Bits 7..1 are compared against a running model of the last load, so a collision that corrupts either field shows up as a mismatch.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter with stretched start bit.
package sertx_pkg;
    // Frame position of the transmitter
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/sertx_cfg.sv
// Turns the raw timing inputs into per-bit lengths.
// Assumes LEN_W is at least CNT_W+1, so bit length plus extension cannot overflow.
// A bit length of 0 is raised to 1. The stop length is clamped so it is never
// shorter than one bit period.
module sertx_cfg #(
    parameter int CNT_W = 5,
    parameter int LEN_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] bit_cycles,
    input  logic [CNT_W-1:0] stop_cycles,
    input  logic [CNT_W-1:0] start_ext,
    output logic [LEN_W-1:0] bit_len,
    output logic [LEN_W-1:0] start_len,
    output logic [LEN_W-1:0] stop_len
);
    logic [LEN_W-1:0] ext_w;
    logic [LEN_W-1:0] stop_w;

    // Derive start, data and stop lengths, with the stop-bit floor
    always_comb begin
        ext_w     = LEN_W'(start_ext);
        stop_w    = LEN_W'(stop_cycles);
        bit_len   = (bit_cycles == '0) ? LEN_W'(1) : LEN_W'(bit_cycles);
        start_len = bit_len + ext_w;
        if (stop_w >= bit_len + ext_w)
            stop_len = stop_w - ext_w;
        else
            stop_len = bit_len;
    end
endmodule

// File: rtl/sertx_fsm.sv
// Frame sequencer. It drives the serial line bit: start, data LSB first, stop.
// It latches the lengths and the byte at acceptance. It accepts a new byte in
// the final stop cycle so back-to-back frames have no gap.
// Assumes lengths are at least 1 (guaranteed by sertx_cfg).
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  bit_len,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [LEN_W-1:0]  stop_len,
    output logic              tx_ready,
    output logic              busy,
    output logic              line
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  bit_q;
    logic [LEN_W-1:0]  stop_q;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              line_q;
    logic              last;
    logic              accept;

    // Handshake: idle, or the final cycle of the stop bit
    always_comb begin
        last     = (cnt == '0);
        tx_ready = (state == ST_IDLE) || (state == ST_STOP && last);
        accept   = tx_valid && tx_ready;
    end

    // Frame state, bit counter, shifter and line register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bit_q  <= '0;
            stop_q <= '0;
            idx    <= '0;
            sh     <= '0;
            line_q <= 1'b1;
        end else if (accept) begin
            state  <= ST_START;
            cnt    <= start_len - LEN_W'(1);
            bit_q  <= bit_len;
            stop_q <= stop_len;
            sh     <= tx_data;
            line_q <= 1'b0;
        end else begin
            case (state)
                ST_START: begin
                    if (last) begin
                        state  <= ST_DATA;
                        cnt    <= bit_q - LEN_W'(1);
                        idx    <= '0;
                        line_q <= sh[0];
                    end else begin
                        cnt <= cnt - LEN_W'(1);
                    end
                end
                ST_DATA: begin
                    if (last) begin
                        if (idx == IDX_W'(DATA_W - 1)) begin
                            state  <= ST_STOP;
                            cnt    <= stop_q - LEN_W'(1);
                            line_q <= 1'b1;
                        end else begin
                            idx    <= idx + IDX_W'(1);
                            sh     <= sh >> 1;
                            line_q <= sh[1];
                            cnt    <= bit_q - LEN_W'(1);
                        end
                    end else begin
                        cnt <= cnt - LEN_W'(1);
                    end
                end
                ST_STOP: begin
                    if (last) begin
                        state  <= ST_IDLE;
                        line_q <= 1'b1;
                    end else begin
                        cnt <= cnt - LEN_W'(1);
                    end
                end
                default: line_q <= 1'b1;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign line = line_q;
endmodule

// File: rtl/sertx_phase.sv
// Holding register for the stepper phase bits of the shared port.
// It loads on its strobe only, so transmitter activity cannot reach it.
module sertx_phase #(
    parameter int PH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PH_W-1:0] val,
    output logic [PH_W-1:0] q
);
    // Capture a new phase pattern on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= val;
    end
endmodule

// File: rtl/sertx_port.sv
// Top level: a serial transmitter with stretched start bit on bit 0 of a
// shared output port. The upper port bits are stepper phases.
// Assumes configuration inputs are valid at the handshake edge. They are
// sampled there and ignored for the rest of the frame.
module sertx_port #(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic [CNT_W-1:0]  bit_cycles,
    input  logic [CNT_W-1:0]  stop_cycles,
    input  logic [CNT_W-1:0]  start_ext,
    input  logic              phase_load,
    input  logic [PORT_W-2:0] phase_val,
    output logic [PORT_W-1:0] port_out,
    output logic              busy
);
    localparam int LEN_W = CNT_W + 1;
    localparam int PH_W  = PORT_W - 1;

    logic [LEN_W-1:0] bit_len;
    logic [LEN_W-1:0] start_len;
    logic [LEN_W-1:0] stop_len;
    logic             line;
    logic [PH_W-1:0]  ph_q;

    sertx_cfg #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
        .bit_cycles  (bit_cycles),
        .stop_cycles (stop_cycles),
        .start_ext   (start_ext),
        .bit_len     (bit_len),
        .start_len   (start_len),
        .stop_len    (stop_len)
    );

    sertx_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .bit_len   (bit_len),
        .start_len (start_len),
        .stop_len  (stop_len),
        .tx_ready  (tx_ready),
        .busy      (busy),
        .line      (line)
    );

    sertx_phase #(.PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (phase_load),
        .val   (phase_val),
        .q     (ph_q)
    );

    // Port assembly: phases above, serial line in bit 0
    assign port_out = {ph_q, line};
endmodule

// File: rtl/sertx_port_chk.sv
// Protocol checker for sertx_port, attached by bind.
module sertx_port_chk #(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              phase_load,
    input logic [PORT_W-2:0] phase_val,
    input logic [PORT_W-1:0] port_out,
    input logic              busy
);
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_load |=> port_out[PORT_W-1:1] == $past(port_out[PORT_W-1:1])); // R7
    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_load |=> port_out[PORT_W-1:1] == $past(phase_val)); // R7
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> port_out[0]); // R8
    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (busy && !port_out[0])); // R2
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_ready); // R6
    AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_ready) |-> port_out[0]); // R9
endmodule

bind sertx_port sertx_port_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .phase_load (phase_load),
    .phase_val  (phase_val),
    .port_out   (port_out),
    .busy       (busy)
);

// File: tb/sertx_port_test.sv
`timescale 1ns/1ps
// Bench for sertx_port: directed corners plus seeded random frames and phase loads.
module sertx_port_test;
    localparam int TR = 16384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic [4:0] bit_cycles = 5'd8;
    logic [4:0] stop_cycles = 5'd12;
    logic [4:0] start_ext = 5'd0;
    logic       phase_load = 1'b0;
    logic [6:0] phase_val = '0;
    logic [7:0] port_out;
    logic       busy;

    int   checks = 0;
    int   errors = 0;
    logic [8:0] trace [0:TR-1];
    int   tpos = 0;
    logic [6:0] exp_ph = '0;
    bit   seen_rst = 0;
    int   ph_cmp = 0;
    int   ph_bad = 0;
    bit   rnd_done = 0;

    sertx_port uut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .bit_cycles(bit_cycles), .stop_cycles(stop_cycles),
        .start_ext(start_ext), .phase_load(phase_load), .phase_val(phase_val),
        .port_out(port_out), .busy(busy)
    );

    always #10 clk = ~clk;

    // Sample mid-cycle, record a trace, and model the phase field (R7)
    always @(posedge clk) begin
        #5;
        if (tpos < TR) trace[tpos] = {busy, port_out};
        tpos++;
        if (!rst_n) begin
            exp_ph   = '0;
            seen_rst = 1;
        end else if (phase_load) begin
            exp_ph = phase_val;
        end
        if (seen_rst) begin
            ph_cmp++;
            if (port_out[7:1] !== exp_ph) ph_bad++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int stop_eff(input int b, input int e, input int s);
        return (s - e >= b) ? (s - e) : b;
    endfunction

    function automatic int frame_len(input int b, input int e, input int s);
        return b + e + 8 * b + stop_eff(b, e, s);
    endfunction

    function automatic logic exp_line(input int t, input logic [7:0] d,
                                      input int b, input int e);
        int st;
        st = b + e;
        if (t < st) return 1'b0;
        if (t < st + 8 * b) return d[(t - st) / b];
        return 1'b1;
    endfunction

    // Called at a negedge; returns at the negedge after acceptance
    task automatic send(input logic [7:0] d, output int sidx);
        tx_valid = 1'b1;
        tx_data  = d;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        sidx     = tpos - 1;
    endtask

    task automatic wait_trace(input int upto);
        while (tpos <= upto) @(negedge clk);
    endtask

    // Compare one frame's line and busy against the requirement waveform
    task automatic check_frame(input string tag, input int sidx, input logic [7:0] d,
                               input int b, input int e, input int s, input bit idle_after);
        int len, bad, fa, fe;
        bad = 0; fa = 0; fe = 0;
        len = frame_len(b, e, s);
        wait_trace(sidx + len + 1);
        for (int t = 0; t < len; t++) begin
            if (sidx + t < TR) begin
                if (trace[sidx + t][0] !== exp_line(t, d, b, e) || trace[sidx + t][8] !== 1'b1) begin
                    if (bad == 0) begin fa = int'(trace[sidx + t][0]); fe = int'(exp_line(t, d, b, e)); end
                    bad++;
                end
            end
        end
        chk(bad == 0, tag, "frame waveform line", fa, fe);
        if (idle_after && sidx + len < TR)
            chk(trace[sidx + len][8] == 1'b0 && trace[sidx + len][0] == 1'b1,
                "R9", "busy/line after stop", int'(trace[sidx + len][8]), 0);
    endtask

    function automatic int busy_run(input int sidx);
        int n;
        n = 0;
        while (sidx + n < tpos && sidx + n < TR && trace[sidx + n][8] == 1'b1) n++;
        return n;
    endfunction

    function automatic int low_run(input int sidx);
        int n;
        n = 0;
        while (sidx + n < tpos && sidx + n < TR && trace[sidx + n][0] == 1'b0) n++;
        return n;
    endfunction

    // Watchdog
    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tpos, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, s1, s2, s3, dummy;
        int rb [0:19];
        int re [0:19];
        int rs [0:19];
        int ri [0:19];
        logic [7:0] rd [0:19];
        dummy = int'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R8 idle line
        chk(port_out == 8'h01, "R1", "port after reset", port_out, 1);
        chk(busy == 1'b0 && tx_ready == 1'b1, "R1", "busy/ready after reset", busy, 0);
        repeat (3) @(negedge clk);
        chk(port_out[0] == 1'b1, "R8", "idle line", port_out[0], 1);

        // R2 R3 R4 default timing
        send(8'hA5, s0);
        check_frame("R2", s0, 8'hA5, 8, 0, 12, 1);
        chk(busy_run(s0) == 9 * 8 + 12, "R4", "busy length ext=0", busy_run(s0), 84);

        // R3 R4 extended start, same total
        start_ext = 5'd2;
        send(8'h3D, s0);
        check_frame("R3", s0, 8'h3D, 8, 2, 12, 1);
        chk(low_run(s0) == 10, "R3", "start length ext=2", low_run(s0), 10);
        chk(busy_run(s0) == 84, "R4", "busy length ext=2", busy_run(s0), 84);

        // R3 11-cycle bit period
        bit_cycles = 5'd11; stop_cycles = 5'd11; start_ext = 5'd0;
        send(8'h81, s0);
        check_frame("R3", s0, 8'h81, 11, 0, 11, 1);
        chk(low_run(s0) == 11, "R3", "start length 11", low_run(s0), 11);

        // R5 stop clamp
        bit_cycles = 5'd8; stop_cycles = 5'd12; start_ext = 5'd6;
        send(8'h7F, s0);
        check_frame("R5", s0, 8'h7F, 8, 6, 12, 1);
        chk(busy_run(s0) == 14 + 64 + 8, "R5", "clamped frame length", busy_run(s0), 86);

        // R6 R9 back to back
        start_ext = 5'd1;
        send(8'h00, s1);
        send(8'hFF, s2);
        send(8'h5A, s3);
        check_frame("R6", s1, 8'h00, 8, 1, 12, 0);
        check_frame("R6", s2, 8'hFF, 8, 1, 12, 0);
        check_frame("R6", s3, 8'h5A, 8, 1, 12, 1);
        chk(s2 - s1 == 84 && s3 - s2 == 84, "R6", "frame spacing", s2 - s1, 84);
        chk(busy_run(s1) == 3 * 84, "R9", "busy held through stream", busy_run(s1), 252);

        // R7 phase load on the accept edge
        phase_load = 1'b1; phase_val = 7'h55;
        send(8'hC3, s0);
        phase_load = 1'b0;
        check_frame("R7", s0, 8'hC3, 8, 1, 12, 1);
        chk(trace[s0][7:1] == 7'h55 && trace[s0][0] == 1'b0, "R7", "phase with start bit",
            int'(trace[s0][7:1]), 'h55);

        // R10 configuration change mid-frame
        start_ext = 5'd0;
        send(8'h96, s0);
        bit_cycles = 5'd5; stop_cycles = 5'd7; start_ext = 5'd3;
        check_frame("R10", s0, 8'h96, 8, 0, 12, 1);

        // Random frames with random phase loads
        fork
            begin
                for (int i = 0; i < 20; i++) begin
                    int g;
                    rb[i] = 4 + int'($urandom % 9);
                    re[i] = int'($urandom % 4);
                    rs[i] = rb[i] + int'($urandom % 9);
                    rd[i] = 8'($urandom);
                    g = int'($urandom % 4);
                    repeat (g) @(negedge clk);
                    bit_cycles = 5'(rb[i]); start_ext = 5'(re[i]); stop_cycles = 5'(rs[i]);
                    send(rd[i], ri[i]);
                end
                wait_trace(ri[19] + frame_len(rb[19], re[19], rs[19]) + 1);
                rnd_done = 1;
            end
            begin
                while (!rnd_done) begin
                    @(negedge clk);
                    if ($urandom % 5 == 0) begin
                        phase_load = 1'b1;
                        phase_val  = 7'($urandom);
                    end else begin
                        phase_load = 1'b0;
                    end
                end
                phase_load = 1'b0;
            end
        join
        for (int i = 0; i < 20; i++)
            check_frame("R2", ri[i], rd[i], rb[i], re[i], rs[i], 0);
        chk(ph_bad == 0, "R7", "phase field mismatches", ph_bad, 0);
        chk(ph_cmp > 1000, "R7", "phase samples taken", ph_cmp, 1000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule